// File: doc/BRIEF.md
# Two-Channel Command-Decoded DAC Register Bank

This block sits behind a serial command front end and turns 8-bit command bytes, each paired with a 16-bit data word, into register updates for a two-channel DAC. Every channel holds a 12-bit setpoint, a 12-bit user K value, a 12-bit DAC input (staging) register and a 12-bit DAC output register. Only the low 12 bits of any data word are used. The upper four bits are ignored.

Writing a setpoint asks an external arithmetic engine for a new DAC code. The block issues a start pulse that carries the channel, the setpoint and the selected K value. When the engine returns its done pulse and result, the code goes either to the input register alone or to both the input and output registers, as the channel's load-mode input selects. A direct input-register write skips the engine. A load command copies the chosen channels' input registers into their output registers. Only one calculation runs at a time. A setpoint write that arrives while a calculation is running is held until the engine is free.

Top module: `dac_cmd_regs`

## Requirements
- R1: Command codes are decoded as follows: 40h and 42h write the setpoint of channel 0 and channel 1; 44h and 46h write their K registers; 48h and 4Ch write their DAC input registers; 50h is the load command.
- R2: After reset, both DAC input and both DAC output registers read zero and no start pulse is issued.
- R3: A setpoint write produces exactly one start pulse, whose channel field is 0 for 40h and 1 for 42h and whose setpoint field is the written 12-bit value.
- R4: The start pulse sets the user-K flag and presents the channel's K register only when that channel's 3-bit K-source input is 010, 101, 110 or 111. For the other four codes, the flag and the K field are zero.
- R5: With the channel's load-mode bit at 0, the returned result enters that channel's input register and the output register keeps its value.
- R6: With the channel's load-mode bit at 1, the returned result enters both the input and the output register of that channel.
- R7: A direct input write (48h/4Ch) loads the register one cycle later. If a result for the same channel arrives in the same cycle, the direct write wins and the result changes neither register of that channel.
- R8: A 50h command whose data bit n is 1 copies channel n's input register into its output register two cycles after the command. The request then clears itself, so a later input write does not reach the output.
- R9: Every other command byte leaves all input and output registers unchanged and starts no calculation.
- R10: At most one calculation is outstanding. Setpoint writes made to a channel while a calculation is running produce one further start, after the done pulse, and that start carries the latest setpoint.
- R11: Data bits 15 to 12 are ignored by every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte and data word valid this cycle |
| cmd_byte | input | 8 | Command byte |
| cmd_data | input | 16 | Data word; bits 11:0 used |
| cfg_load_both | input | 2 | Per-channel load mode: 1 sends results to input and output |
| cfg_ksrc | input | 6 | Per-channel 3-bit K-source select, channel n at bits 3n+2:3n |
| calc_start | output | 1 | One-cycle request to the arithmetic engine |
| calc_chan | output | 1 | Channel of the request |
| calc_vset | output | 12 | Setpoint for the request |
| calc_k | output | 12 | User K value, zero when not selected |
| calc_kuser | output | 1 | User K register selected for this request |
| calc_done | input | 1 | Engine finished; result valid |
| calc_result | input | 12 | Computed DAC code |
| dac_in | output | 24 | DAC input registers, channel n at bits 12n+11:12n |
| dac_out | output | 24 | DAC output registers, channel n at bits 12n+11:12n |

## Verification
The bench first sends all 256 command bytes. The unassigned bytes must leave the registers untouched, which separates true decoding from a decoder that only checks a few bits. Every K-source code is then tried on both channels with distinct K and setpoint values, and the bench's own result model catches a wrong channel route, a wrong K gate or a wrong load mode. Back-to-back setpoint writes to a busy engine test the queueing. A done pulse placed in the same cycle as a direct write tests the override rule. Load commands with differing bit masks test per-channel transfer and the self-clear.

// File: rtl/dac_cmd_pkg.sv
// Package: command codes, K-source decode and shared widths for the DAC
// register bank. Assumes channel codes follow a fixed stride per register kind.
package dac_cmd_pkg;

    localparam int CMD_W  = 8;
    localparam int DATA_W = 16;
    localparam int KSRC_W = 3;

    localparam logic [CMD_W-1:0] CMD_LOAD = 8'h50;

    // Setpoint write code for channel ch
    function automatic logic [CMD_W-1:0] cmd_vset(input int ch);
        logic [CMD_W-1:0] r;
        r = 8'h40 + 8'(2 * ch);
        return r;
    endfunction

    // K register write code for channel ch
    function automatic logic [CMD_W-1:0] cmd_k(input int ch);
        logic [CMD_W-1:0] r;
        r = 8'h44 + 8'(2 * ch);
        return r;
    endfunction

    // Direct input register write code for channel ch
    function automatic logic [CMD_W-1:0] cmd_din(input int ch);
        logic [CMD_W-1:0] r;
        r = 8'h48 + 8'(4 * ch);
        return r;
    endfunction

    // True when the K-source code selects the user K register
    function automatic logic ksrc_uses_user(input logic [KSRC_W-1:0] s);
        return (s == 3'b010) || (s == 3'b101) || (s == 3'b110) || (s == 3'b111);
    endfunction

endpackage

// File: rtl/dac_cmd_decode.sv
// Module: dac_cmd_decode
// Turns a valid command byte into one-hot write strobes per channel and a
// load strobe. Purely combinational. Assumes the codes from dac_cmd_pkg do
// not collide for the configured channel count.
module dac_cmd_decode
    import dac_cmd_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_byte,
    output logic [NCH-1:0]    wr_vset,
    output logic [NCH-1:0]    wr_k,
    output logic [NCH-1:0]    wr_din,
    output logic              wr_load
);

    // Per-channel strobes, one comparator set per channel
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wr_vset[i] = cmd_valid && (cmd_byte == cmd_vset(i));
        assign wr_k[i]    = cmd_valid && (cmd_byte == cmd_k(i));
        assign wr_din[i]  = cmd_valid && (cmd_byte == cmd_din(i));
    end

    // Shared load command strobe
    assign wr_load = cmd_valid && (cmd_byte == CMD_LOAD);

endmodule

// File: rtl/dac_chan_regs.sv
// Module: dac_chan_regs
// Register set of one channel: setpoint, user K, DAC input and DAC output.
// A direct input write has priority over an engine result. An output
// transfer copies the input value held before this cycle's updates.
// The K register has no reset value by design.
module dac_chan_regs #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_vset,
    input  logic          wr_k,
    input  logic          wr_din,
    input  logic [DW-1:0] wdata,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    input  logic          load_both,
    input  logic          xfer,
    output logic [DW-1:0] vset_q,
    output logic [DW-1:0] k_q,
    output logic [DW-1:0] din_q,
    output logic [DW-1:0] dout_q
);

    logic res_take;

    // An engine result is dropped when a direct write hits the same cycle
    assign res_take = res_valid && !wr_din;

    // Setpoint register, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            vset_q <= '0;
        else if (wr_vset)
            vset_q <= wdata;
    end

    // User K register, no defined reset value
    always_ff @(posedge clk) begin
        if (wr_k)
            k_q <= wdata;
    end

    // DAC input register: direct write first, then engine result
    always_ff @(posedge clk) begin
        if (!rst_n)
            din_q <= '0;
        else if (wr_din)
            din_q <= wdata;
        else if (res_take)
            din_q <= res_data;
    end

    // DAC output register: result in load-both mode, else load transfer
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= '0;
        else if (res_take && load_both)
            dout_q <= res_data;
        else if (xfer)
            dout_q <= din_q;
    end

endmodule

// File: rtl/dac_calc_sched.sv
// Module: dac_calc_sched
// Keeps one pending flag per channel and runs at most one engine request at
// a time. The lowest pending channel is started first. The request samples
// the setpoint at launch, so later writes to a waiting channel merge into
// one run with the latest value. A done pulse while idle is ignored.
module dac_calc_sched
    import dac_cmd_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 12,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        wr_vset,
    input  logic [NCH*DW-1:0]     vset_flat,
    input  logic [NCH*DW-1:0]     k_flat,
    input  logic [NCH*KSRC_W-1:0] ksrc_flat,
    input  logic                  calc_done,
    output logic                  calc_start,
    output logic [CHW-1:0]        calc_chan,
    output logic [DW-1:0]         calc_vset,
    output logic [DW-1:0]         calc_k,
    output logic                  calc_kuser,
    output logic [NCH-1:0]        res_valid
);

    logic [NCH-1:0] pend_q;
    logic           busy_q;
    logic [CHW-1:0] cur_q;
    logic           pick_vld;
    logic [CHW-1:0] pick_idx;
    logic [DW-1:0]  sel_vset;
    logic [DW-1:0]  sel_k;
    logic           sel_user;
    logic           launch;
    logic [NCH-1:0] launch_mask;

    // Pick the lowest pending channel and gather its operands
    always_comb begin
        pick_vld = 1'b0;
        pick_idx = '0;
        sel_vset = '0;
        sel_k    = '0;
        sel_user = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                pick_vld = 1'b1;
                pick_idx = CHW'(i);
                sel_vset = vset_flat[i*DW +: DW];
                sel_user = ksrc_uses_user(ksrc_flat[i*KSRC_W +: KSRC_W]);
                sel_k    = sel_user ? k_flat[i*DW +: DW] : '0;
            end
        end
    end

    assign launch = pick_vld && !busy_q;

    // One-hot mask of the channel launched this cycle
    always_comb begin
        for (int i = 0; i < NCH; i++)
            launch_mask[i] = launch && (pick_idx == CHW'(i));
    end

    // Pending flags: set by setpoint writes, cleared on launch
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~launch_mask) | wr_vset;
    end

    // Engine occupancy and owner channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            cur_q  <= pick_idx;
        end else if (calc_done) begin
            busy_q <= 1'b0;
        end
    end

    // Registered request towards the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            calc_start <= 1'b0;
            calc_chan  <= '0;
            calc_vset  <= '0;
            calc_k     <= '0;
            calc_kuser <= 1'b0;
        end else begin
            calc_start <= launch;
            if (launch) begin
                calc_chan  <= pick_idx;
                calc_vset  <= sel_vset;
                calc_k     <= sel_k;
                calc_kuser <= sel_user;
            end
        end
    end

    // Route the done pulse to the owning channel
    always_comb begin
        for (int i = 0; i < NCH; i++)
            res_valid[i] = calc_done && busy_q && (cur_q == CHW'(i));
    end

endmodule

// File: rtl/dac_cmd_regs.sv
// Module: dac_cmd_regs (top)
// Command-decoded, double-buffered DAC register bank with an external
// calculation handshake. Assumes DW <= 16, since data comes from the low bits of
// the data word, and NCH <= 16, since load bits come from cmd_data[NCH-1:0].
module dac_cmd_regs
    import dac_cmd_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 12,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [CMD_W-1:0]      cmd_byte,
    input  logic [DATA_W-1:0]     cmd_data,
    input  logic [NCH-1:0]        cfg_load_both,
    input  logic [NCH*KSRC_W-1:0] cfg_ksrc,
    output logic                  calc_start,
    output logic [CHW-1:0]        calc_chan,
    output logic [DW-1:0]         calc_vset,
    output logic [DW-1:0]         calc_k,
    output logic                  calc_kuser,
    input  logic                  calc_done,
    input  logic [DW-1:0]         calc_result,
    output logic [NCH*DW-1:0]     dac_in,
    output logic [NCH*DW-1:0]     dac_out
);

    logic [NCH-1:0]    wr_vset;
    logic [NCH-1:0]    wr_k;
    logic [NCH-1:0]    wr_din;
    logic              wr_load;
    logic [NCH-1:0]    load_q;
    logic [NCH-1:0]    res_valid;
    logic [NCH*DW-1:0] vset_flat;
    logic [NCH*DW-1:0] k_flat;
    logic [DW-1:0]     wdata;
    logic              unused_hi;

    assign wdata     = cmd_data[DW-1:0];
    assign unused_hi = ^cmd_data[DATA_W-1:DW];

    dac_cmd_decode #(.NCH(NCH)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .wr_vset   (wr_vset),
        .wr_k      (wr_k),
        .wr_din    (wr_din),
        .wr_load   (wr_load)
    );

    // Load request bits: set by the load command, cleared one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_q <= '0;
        else
            load_q <= wr_load ? cmd_data[NCH-1:0] : '0;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dac_chan_regs #(.DW(DW)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_vset   (wr_vset[i]),
            .wr_k      (wr_k[i]),
            .wr_din    (wr_din[i]),
            .wdata     (wdata),
            .res_valid (res_valid[i]),
            .res_data  (calc_result),
            .load_both (cfg_load_both[i]),
            .xfer      (load_q[i]),
            .vset_q    (vset_flat[i*DW +: DW]),
            .k_q       (k_flat[i*DW +: DW]),
            .din_q     (dac_in[i*DW +: DW]),
            .dout_q    (dac_out[i*DW +: DW])
        );
    end

    dac_calc_sched #(.NCH(NCH), .DW(DW)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_vset    (wr_vset),
        .vset_flat  (vset_flat),
        .k_flat     (k_flat),
        .ksrc_flat  (cfg_ksrc),
        .calc_done  (calc_done),
        .calc_start (calc_start),
        .calc_chan  (calc_chan),
        .calc_vset  (calc_vset),
        .calc_k     (calc_k),
        .calc_kuser (calc_kuser),
        .res_valid  (res_valid)
    );

endmodule

// File: rtl/dac_cmd_regs_chk.sv
// Module: dac_cmd_regs_chk
// Port-level checker bound to dac_cmd_regs. It tracks engine occupancy on
// its own and checks handshake and register update rules.
module dac_cmd_regs_chk
    import dac_cmd_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 12,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic [CMD_W-1:0]      cmd_byte,
    input logic [DATA_W-1:0]     cmd_data,
    input logic [NCH-1:0]        cfg_load_both,
    input logic                  calc_start,
    input logic [CHW-1:0]        calc_chan,
    input logic                  calc_done,
    input logic [DW-1:0]         calc_result,
    input logic [NCH*DW-1:0]     dac_in,
    input logic [NCH*DW-1:0]     dac_out
);

    logic           chk_busy;
    logic [CHW-1:0] chk_chan;
    logic           known;

    // Independent record of the outstanding request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_busy <= 1'b0;
            chk_chan <= '0;
        end else if (calc_start) begin
            chk_busy <= 1'b1;
            chk_chan <= calc_chan;
        end else if (calc_done) begin
            chk_busy <= 1'b0;
        end
    end

    // Whether the current command byte is one the bank recognises
    always_comb begin
        known = (cmd_byte == CMD_LOAD);
        for (int i = 0; i < NCH; i++)
            if (cmd_byte == cmd_vset(i) || cmd_byte == cmd_k(i) || cmd_byte == cmd_din(i))
                known = 1'b1;
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        calc_start |=> !calc_start); // R3

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        calc_start |-> !chk_busy); // R10

    AST_UNKNOWN_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !known && !calc_done) |=> ($stable(dac_in) && !calc_start)); // R9

    for (genvar i = 0; i < NCH; i++) begin : g_ast
        AST_DIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_byte == cmd_din(i)) |=> dac_in[i*DW +: DW] == $past(cmd_data[DW-1:0])); // R7

        AST_BOTH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            (calc_done && chk_busy && chk_chan == CHW'(i) && cfg_load_both[i]
             && !(cmd_valid && cmd_byte == cmd_din(i)))
            |=> dac_out[i*DW +: DW] == $past(calc_result)); // R6
    end

endmodule

bind dac_cmd_regs dac_cmd_regs_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_byte      (cmd_byte),
    .cmd_data      (cmd_data),
    .cfg_load_both (cfg_load_both),
    .calc_start    (calc_start),
    .calc_chan     (calc_chan),
    .calc_done     (calc_done),
    .calc_result   (calc_result),
    .dac_in        (dac_in),
    .dac_out       (dac_out)
);

// File: tb/sim_dac_cmd_regs.sv
// Bench for dac_cmd_regs with a behavioural arithmetic engine (fixed latency)
module sim_dac_cmd_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic [15:0] cmd_data = '0;
    logic [1:0]  cfg_load_both = '0;
    logic [5:0]  cfg_ksrc = '0;
    logic        calc_start;
    logic        calc_chan;
    logic [11:0] calc_vset;
    logic [11:0] calc_k;
    logic        calc_kuser;
    logic        calc_done;
    logic [11:0] calc_result;
    logic [23:0] dac_in;
    logic [23:0] dac_out;

    logic        eng_done = 1'b0;
    logic [11:0] eng_res = '0;
    logic        man_done = 1'b0;
    logic [11:0] man_res = '0;
    logic        eng_auto = 1'b1;
    int          eng_cnt = 0;
    int          n_start = 0;
    logic        last_chan = 1'b0;
    logic [11:0] last_vset = '0;
    logic [11:0] last_k = '0;
    logic        last_kuser = 1'b0;
    int          n_tests = 0;
    int          n_fail = 0;
    int          cyc = 0;

    assign calc_done   = eng_done | man_done;
    assign calc_result = man_done ? man_res : eng_res;

    always #4 clk = ~clk;

    dac_cmd_regs u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .cmd_data(cmd_data), .cfg_load_both(cfg_load_both), .cfg_ksrc(cfg_ksrc),
        .calc_start(calc_start), .calc_chan(calc_chan), .calc_vset(calc_vset),
        .calc_k(calc_k), .calc_kuser(calc_kuser), .calc_done(calc_done),
        .calc_result(calc_result), .dac_in(dac_in), .dac_out(dac_out)
    );

    function automatic logic [11:0] model(input logic [11:0] v, input logic [11:0] k);
        return 12'(v * 3 + k);
    endfunction

    function automatic logic user_sel(input logic [2:0] s);
        return (s == 3'd2) || (s == 3'd5) || (s == 3'd6) || (s == 3'd7);
    endfunction

    // Engine: latency of three falling edges after the start is seen
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt = eng_cnt - 1;
            if (eng_cnt == 0) begin
                eng_done = 1'b1;
                eng_res  = model(last_vset, last_k);
            end
        end
        if (calc_start) begin
            n_start    = n_start + 1;
            last_chan  = calc_chan;
            last_vset  = calc_vset;
            last_k     = calc_k;
            last_kuser = calc_kuser;
            if (eng_auto) eng_cnt = 3;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] c, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = c; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] in_s, out_s;
        int          s0;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R2 reset state
        chk("R2 dac_in", dac_in, 0);
        chk("R2 dac_out", dac_out, 0);
        chk("R2 no start", n_start, 0);

        // R8 load both channels after direct writes (R1 codes 48h/4Ch/50h)
        wr(8'h48, 16'h0123);
        wr(8'h4C, 16'h0456);
        wr(8'h50, 16'h0003);
        idle(1);
        chk("R8 load both", dac_out, 24'h456123);

        // R9 sweep of every unassigned command byte
        for (int b = 0; b < 256; b++) begin
            if (b == 8'h40 || b == 8'h42 || b == 8'h44 || b == 8'h46 ||
                b == 8'h48 || b == 8'h4C || b == 8'h50) continue;
            s0 = n_start;
            wr(8'(b), 16'hFFFF);
            idle(2);
            chk($sformatf("R9 byte %02h in", b), dac_in, 24'h456123);
            chk($sformatf("R9 byte %02h out/start", b), {dac_out, 8'(n_start - s0)}, {24'h456123, 8'h00});
        end

        // R3 R4 R5 R11: every K-source code on both channels, load mode 0
        cfg_load_both = 2'b00;
        for (int ch = 0; ch < 2; ch++) begin
            for (int s = 0; s < 8; s++) begin
                logic [11:0] kv, vv, ke;
                cfg_ksrc[ch*3 +: 3] = 3'(s);
                kv = 12'(12'h100 + s * 17 + ch * 5);
                vv = 12'(12'h200 + s * 9 + ch * 64);
                ke = user_sel(3'(s)) ? kv : 12'h000;
                out_s = dac_out;
                s0 = n_start;
                wr(8'(8'h44 + 2 * ch), {4'hF, kv});
                wr(8'(8'h40 + 2 * ch), {4'hA, vv});
                idle(8);
                chk("R3 one start", n_start - s0, 1);
                chk("R3 channel", last_chan, ch);
                chk("R3 R11 setpoint", last_vset, vv);
                chk("R4 kuser flag", last_kuser, user_sel(3'(s)));
                chk("R4 k value", last_k, ke);
                chk("R5 input gets result", dac_in[ch*12 +: 12], model(vv, ke));
                chk("R5 output held", dac_out, out_s);
            end
        end

        // R6 load-both mode
        cfg_load_both = 2'b11;
        cfg_ksrc = '0;
        for (int ch = 0; ch < 2; ch++) begin
            logic [11:0] vv;
            vv = 12'(12'h3C1 + ch * 12'h222);
            wr(8'(8'h40 + 2 * ch), {4'h0, vv});
            idle(8);
            chk("R6 input", dac_in[ch*12 +: 12], model(vv, 12'h0));
            chk("R6 output", dac_out[ch*12 +: 12], model(vv, 12'h0));
        end

        // R7 R11 direct writes ignore the upper data bits
        cfg_load_both = 2'b00;
        out_s = dac_out;
        wr(8'h48, 16'hF3AB);
        chk("R7 R11 direct ch0", dac_in[11:0], 12'h3AB);
        wr(8'h4C, 16'hC5A1);
        chk("R7 R11 direct ch1", dac_in[23:12], 12'h5A1);
        chk("R7 output untouched", dac_out, out_s);

        // R8 per-channel transfer and self-clear
        wr(8'h50, 16'hFFFE);
        idle(1);
        chk("R8 ch1 transferred", dac_out[23:12], 12'h5A1);
        chk("R8 ch0 kept", dac_out[11:0], out_s[11:0]);
        wr(8'h4C, 16'h0111);
        idle(2);
        chk("R8 self-clear", dac_out[23:12], 12'h5A1);
        out_s = dac_out;
        wr(8'h50, 16'hFFFC);
        idle(2);
        chk("R8 zero mask", dac_out, out_s);

        // R10 queued setpoint writes during a running calculation
        s0 = n_start;
        wr(8'h40, 16'h0010);
        wr(8'h40, 16'h0020);
        wr(8'h40, 16'h0030);
        idle(20);
        chk("R10 start count", n_start - s0, 2);
        chk("R10 latest setpoint", last_vset, 12'h030);
        chk("R10 result", dac_in[11:0], model(12'h030, 12'h0));

        // R7 direct write beats a same-cycle result, load-both on channel 0
        cfg_load_both = 2'b01;
        eng_auto = 1'b0;
        out_s = dac_out;
        in_s = dac_in;
        wr(8'h40, 16'h0077);
        @(negedge clk);
        chk("R7 start seen", calc_start, 1);
        @(negedge clk);
        man_done = 1'b1; man_res = 12'hABC;
        cmd_valid = 1'b1; cmd_byte = 8'h48; cmd_data = 16'h0055;
        @(negedge clk);
        man_done = 1'b0; cmd_valid = 1'b0;
        chk("R7 collision input", dac_in[11:0], 12'h055);
        chk("R7 collision output", dac_out[11:0], out_s[11:0]);
        chk("R7 other channel", dac_in[23:12], in_s[23:12]);
        eng_auto = 1'b1;

        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule